// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Sense Control

This block collects a small, parameterized set of external interrupt lines and presents one interrupt request to a single processor. Each line has its own configuration word with a vector number, a priority, a polarity bit, a sense bit (edge or level) and a mask bit. Every line goes through a two-flop synchronizer and then a per-source state machine with two states. `SRC_QUIET` moves to `SRC_PEND` on an active edge, or when the level is active in level mode. `SRC_PEND` returns to `SRC_QUIET` when the source is acknowledged in edge mode, or when the level goes inactive in level mode. An edge stays latched while the source is masked. Setting a masked source to level sense while its input is inactive discards a stale edge, so edges captured at power-up can be dropped before the source is unmasked.

An arbiter selects, among the unmasked pending sources, the one with the highest priority. That priority must be strictly greater than the task-priority threshold and strictly greater than the priority of the highest source already in service. Software reads the acknowledge register to take the winning vector. That read moves the source into service. Software writes the end-of-interrupt register to retire the highest-priority source in service. A read-only feature register gives the source count, so a drain loop knows how many acknowledge/EOI rounds to run.

The register bus has single-cycle writes and one-cycle read latency. A two-state machine (`BUS_IDLE`, `BUS_RESP`) generates the read-valid flag. A read strobe moves it to `BUS_RESP`. It stays in `BUS_RESP` while read strobes continue back to back, and returns to `BUS_IDLE` on the first cycle without one. Word addresses: 0 global config (bit 0 delivery enable), 1 feature, 2 task priority, 3 acknowledge, 4 end-of-interrupt, 5 spurious vector, 16+i configuration word of source i.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source configuration word reads 0x8100_0000 (mask bit 31 = 1, polarity bit 24 = 1 meaning rising edge / high level, sense bit 25 = 0 meaning edge, priority bits 19:16 = 0, vector bits 7:0 = 0). Global config reads 0, the spurious vector reads 0xFF and `irq_o` is 0.
- R2: The feature register returns NSRC, and writes to it have no effect.
- R3: In edge sense, an active edge latches the source as pending, and it stays pending while the source is masked. Once the source is unmasked, it is requested.
- R4: In level sense, pending follows the input level: active-high when polarity = 1, active-low when polarity = 0. Polarity 0 in edge sense latches falling edges.
- R5: Switching a masked source to level sense while its input is inactive clears a latched edge. Returning it to edge sense and unmasking it then raises no request.
- R6: A source qualifies only if its priority is strictly greater than the task priority. Priority 0 never qualifies.
- R7: An acknowledge read returns the vector of the qualifying source with the highest priority, ties going to the lowest index. The read clears that source's edge latch and marks the source in service.
- R8: An acknowledge read with no qualifying source returns the spurious vector and changes no state.
- R9: A source is requested only if its priority is strictly greater than that of every source in service. A higher-priority source nests.
- R10: An EOI write clears only the in-service mark of the highest-priority source in service.
- R11: `irq_o` is 0 while the delivery-enable bit is 0. Acknowledge reads still work.
- R12: Read data and `bus_rvalid` appear one cycle after `bus_rd`. `bus_rvalid` is 0 in a cycle that follows no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NSRC | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is the stale power-up edge. The edge must be latched while the source is still masked, then discarded through a round trip to level sense, and the source unmasked afterwards without a request. The stimulus pulses a masked line, reprograms the sense twice and only then clears the mask. The same pulse without the round trip is expected to produce the vector. Nested service also needs several steps. Two sources must be in service together with a lower-priority source pending, and directed sequences build that state before each EOI. Constrained random pulses, acknowledges, EOIs and threshold changes are then compared with a bench model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int VEC_W  = 8;
    localparam int PRI_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam int CFG_PRI_LSB   = 16;
    localparam int CFG_POL_BIT   = 24;
    localparam int CFG_SENSE_BIT = 25;
    localparam int CFG_MASK_BIT  = 31;

    localparam int A_GCFG     = 0;
    localparam int A_FEAT     = 1;
    localparam int A_TASK     = 2;
    localparam int A_ACK      = 3;
    localparam int A_EOI      = 4;
    localparam int A_SPUR     = 5;
    localparam int A_SRC_BASE = 16;

    typedef struct packed {
        logic             mask;
        logic             level;
        logic             pol_hi;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } src_cfg_t;

    typedef enum logic [0:0] {SRC_QUIET, SRC_PEND} src_state_t;
    typedef enum logic [0:0] {BUS_IDLE, BUS_RESP} bus_state_t;
endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell
    import prio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pin,
    input  logic level,
    input  logic pol_hi,
    input  logic ack_clr,
    output logic pending
);
    logic [2:0] sh_q;
    src_state_t st_q, st_d;
    logic sync_v, prev_v, active, edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], irq_pin};
    end

    assign sync_v   = sh_q[1];
    assign prev_v   = sh_q[2];
    assign active   = pol_hi ? sync_v : !sync_v;
    assign edge_hit = pol_hi ? (sync_v & !prev_v) : (!sync_v & prev_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SRC_QUIET: begin
                if (level ? active : edge_hit) st_d = SRC_PEND;
            end
            SRC_PEND: begin
                if (level) begin
                    if (!active) st_d = SRC_QUIET;
                end else if (ack_clr && !edge_hit) begin
                    st_d = SRC_QUIET;
                end
            end
            default: st_d = SRC_QUIET;
        endcase
    end

    always_comb pending = (st_q == SRC_PEND);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !level && !ack_clr) |=> pending);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][PRI_W-1:0] pri,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx,
    output logic [PRI_W-1:0]           top_pri
);
    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        top_pri = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!hit || pri[i] > top_pri)) begin
                hit     = 1'b1;
                idx     = IDX_W'(i);
                top_pri = pri[i];
            end
        end
    end
endmodule

// File: rtl/pic_bus_fsm.sv
module pic_bus_fsm
    import prio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic rvalid
);
    bus_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (rd_req)  st_d = BUS_RESP;
            BUS_RESP: if (!rd_req) st_d = BUS_IDLE;
            default:  st_d = BUS_IDLE;
        endcase
    end

    always_comb rvalid = (st_q == BUS_RESP);

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    // R12
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    src_cfg_t                  cfg_q [NSRC];
    logic                      gcfg_en;
    logic [PRI_W-1:0]          task_q;
    logic [VEC_W-1:0]          spur_q;
    logic [NSRC-1:0]           pend, isr_q, elig, ack_clr, src_hit;
    logic [NSRC-1:0][PRI_W-1:0] pri_vec;
    logic                      win_hit, top_hit;
    logic [IDX_W-1:0]          win_idx, top_idx;
    logic [PRI_W-1:0]          win_pri, top_pri;
    logic                      ack_stb, eoi_stb;
    logic [DATA_W-1:0]         rd_mux;

    assign ack_stb = bus_rd && (bus_addr == ADDR_W'(A_ACK));
    assign eoi_stb = bus_wr && (bus_addr == ADDR_W'(A_EOI));

    function automatic logic [DATA_W-1:0] pack_cfg(input src_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]              = c.vec;
        w[CFG_PRI_LSB +: PRI_W]   = c.pri;
        w[CFG_POL_BIT]            = c.pol_hi;
        w[CFG_SENSE_BIT]          = c.level;
        w[CFG_MASK_BIT]           = c.mask;
        return w;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcfg_en <= 1'b0;
            task_q  <= '0;
            spur_q  <= '1;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_GCFG)) gcfg_en <= bus_wdata[0];
            if (bus_addr == ADDR_W'(A_TASK)) task_q  <= bus_wdata[PRI_W-1:0];
            if (bus_addr == ADDR_W'(A_SPUR)) spur_q  <= bus_wdata[VEC_W-1:0];
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = (bus_addr == ADDR_W'(A_SRC_BASE + i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '{mask: 1'b1, level: 1'b0, pol_hi: 1'b1, pri: '0, vec: '0};
            end else if (bus_wr && src_hit[i]) begin
                cfg_q[i].mask   <= bus_wdata[CFG_MASK_BIT];
                cfg_q[i].level  <= bus_wdata[CFG_SENSE_BIT];
                cfg_q[i].pol_hi <= bus_wdata[CFG_POL_BIT];
                cfg_q[i].pri    <= bus_wdata[CFG_PRI_LSB +: PRI_W];
                cfg_q[i].vec    <= bus_wdata[VEC_W-1:0];
            end
        end

        pic_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_pin (irq_in[i]),
            .level   (cfg_q[i].level),
            .pol_hi  (cfg_q[i].pol_hi),
            .ack_clr (ack_clr[i]),
            .pending (pend[i])
        );

        assign pri_vec[i] = cfg_q[i].pri;
        assign elig[i]    = pend[i] && !cfg_q[i].mask &&
                            (cfg_q[i].pri > task_q) && (cfg_q[i].pri > top_pri);
        assign ack_clr[i] = ack_stb && win_hit && (win_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                isr_q[i] <= 1'b0;
            else if (ack_clr[i])
                isr_q[i] <= 1'b1;
            else if (eoi_stb && top_hit && (top_idx == IDX_W'(i)))
                isr_q[i] <= 1'b0;
        end
    end

    pic_arbiter #(.NSRC(NSRC)) u_isr_arb (
        .req     (isr_q),
        .pri     (pri_vec),
        .hit     (top_hit),
        .idx     (top_idx),
        .top_pri (top_pri)
    );

    pic_arbiter #(.NSRC(NSRC)) u_win_arb (
        .req     (elig),
        .pri     (pri_vec),
        .hit     (win_hit),
        .idx     (win_idx),
        .top_pri (win_pri)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(A_GCFG): rd_mux = DATA_W'(gcfg_en);
            ADDR_W'(A_FEAT): rd_mux = DATA_W'(NSRC);
            ADDR_W'(A_TASK): rd_mux = DATA_W'(task_q);
            ADDR_W'(A_ACK):  rd_mux = win_hit ? DATA_W'(cfg_q[win_idx].vec) : DATA_W'(spur_q);
            ADDR_W'(A_SPUR): rd_mux = DATA_W'(spur_q);
            default:         rd_mux = '0;
        endcase
        for (int i = 0; i < NSRC; i++) begin
            if (src_hit[i]) rd_mux = pack_cfg(cfg_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    pic_bus_fsm u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (bus_rd),
        .rvalid (bus_rvalid)
    );

    assign irq_o = gcfg_en && win_hit;

    // R6
    above_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (win_pri > task_q));
    // R9
    above_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && top_hit) |-> (win_pri > top_pri));
    // R7
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr));
    // R7
    ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && win_hit && !bus_wr) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));
    // R10
    eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && top_hit && !ack_stb) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int NSRC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_in = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              irq_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_vec [NSRC];
    logic [3:0] m_pri [NSRC];
    logic [NSRC-1:0] m_pend, m_isr;
    logic [3:0] m_task;

    prio_irq_ctrl #(.NSRC(NSRC)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        chk(bus_rvalid === 1'b1, "R12 rvalid", 32'(bus_rvalid), 32'd1);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d === exp, req, d, exp);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        repeat (2) @(negedge clk);
        chk(irq_o === exp, req, 32'(irq_o), 32'(exp));
    endtask

    task automatic pulse(input int i, input logic rest);
        @(negedge clk); irq_in[i] = ~rest;
        repeat (4) @(negedge clk);
        irq_in[i] = rest;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_top();
        int t = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_isr[i] && (t < 0 || m_pri[i] > m_pri[t])) t = i;
        return t;
    endfunction

    function automatic int model_win();
        int w = -1;
        int t = model_top();
        logic [3:0] floor_p = (t < 0) ? 4'd0 : m_pri[t];
        for (int i = 0; i < NSRC; i++)
            if (m_pend[i] && m_pri[i] > m_task && m_pri[i] > floor_p &&
                (w < 0 || m_pri[i] > m_pri[w])) w = i;
        return w;
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq_o === 1'b0, "R1 irq after reset", 32'(irq_o), 32'd0);
        expect_rd(6'd16, 32'h8100_0000, "R1 cfg0 reset");
        expect_rd(6'd19, 32'h8100_0000, "R1 cfg3 reset");
        expect_rd(6'd5, 32'h0000_00FF, "R1 spurious reset");
        expect_rd(6'd0, 32'h0, "R1 gcfg reset");
        @(negedge clk);
        chk(bus_rvalid === 1'b0, "R12 rvalid drop", 32'(bus_rvalid), 32'd0);

        // R2 feature register
        expect_rd(6'd1, 32'(NSRC), "R2 feature");
        wr(6'd1, 32'h55);
        expect_rd(6'd1, 32'(NSRC), "R2 feature after write");

        // R3 edge captured while masked survives until unmask
        wr(6'd0, 32'h1);
        wr(6'd16, 32'h8103_0020);
        pulse(0, 1'b0);
        expect_irq(1'b0, "R3 masked no irq");
        wr(6'd16, 32'h0103_0020);
        expect_irq(1'b1, "R3 kept edge");
        expect_rd(6'd3, 32'h20, "R7 ack src0");
        expect_irq(1'b0, "R7 pending cleared");
        wr(6'd4, 32'h0);

        // R5 stale edge discarded via level sense
        wr(6'd17, 32'h8103_0021);
        pulse(1, 1'b0);
        wr(6'd17, 32'h8303_0021);
        settle(3);
        wr(6'd17, 32'h8103_0021);
        wr(6'd17, 32'h0103_0021);
        expect_irq(1'b0, "R5 no false irq");
        expect_rd(6'd3, 32'hFF, "R5 spurious after discard");

        // R4 level active-low, then falling edge
        wr(6'd18, 32'h0205_0022);
        settle(4);
        chk(irq_o === 1'b1, "R4 low level active", 32'(irq_o), 32'd1);
        irq_in[2] = 1'b1;
        settle(5);
        chk(irq_o === 1'b0, "R4 high level inactive", 32'(irq_o), 32'd0);
        irq_in[2] = 1'b0;
        settle(5);
        expect_rd(6'd3, 32'h22, "R4 level ack");
        irq_in[2] = 1'b1;
        settle(5);
        wr(6'd4, 32'h0);
        wr(6'd18, 32'h0005_0022);
        pulse(2, 1'b1);
        expect_irq(1'b1, "R4 falling edge latched");
        expect_rd(6'd3, 32'h22, "R4 falling ack");
        wr(6'd4, 32'h0);
        wr(6'd18, 32'h8005_0022);

        // R6 threshold and R8 spurious without side effects
        wr(6'd19, 32'h0002_0023);
        wr(6'd2, 32'h2);
        pulse(3, 1'b0);
        expect_irq(1'b0, "R6 equal to task blocked");
        expect_rd(6'd3, 32'hFF, "R8 spurious vector");
        wr(6'd2, 32'h1);
        expect_irq(1'b1, "R8 spurious read kept pending");
        expect_rd(6'd3, 32'h23, "R6 above task ack");
        wr(6'd4, 32'h0);
        wr(6'd2, 32'h0);
        wr(6'd19, 32'h0000_0023);
        pulse(3, 1'b0);
        expect_irq(1'b0, "R6 priority zero");
        expect_rd(6'd3, 32'hFF, "R6 priority zero spurious");
        wr(6'd19, 32'h8300_0023);
        settle(3);
        wr(6'd19, 32'h0004_0023);
        expect_irq(1'b0, "R5 level round trip clears");

        // R11 delivery enable
        wr(6'd0, 32'h0);
        pulse(3, 1'b0);
        expect_irq(1'b0, "R11 disabled");
        expect_rd(6'd0, 32'h0, "R11 gcfg readback");
        wr(6'd0, 32'h1);
        expect_irq(1'b1, "R11 enabled");
        expect_rd(6'd3, 32'h23, "R11 ack");
        wr(6'd4, 32'h0);

        // R9 nesting and R10 EOI order
        wr(6'd17, 32'h0006_0021);
        pulse(0, 1'b0);
        expect_rd(6'd3, 32'h20, "R9 first ack");
        pulse(1, 1'b0);
        expect_irq(1'b1, "R9 higher nests");
        expect_rd(6'd3, 32'h21, "R9 nested ack");
        pulse(0, 1'b0);
        expect_irq(1'b0, "R9 equal blocked");
        pulse(3, 1'b0);
        expect_irq(1'b0, "R9 below top blocked");
        wr(6'd4, 32'h0);
        expect_irq(1'b1, "R10 top retired first");
        expect_rd(6'd3, 32'h23, "R10 next winner");
        wr(6'd4, 32'h0);
        expect_irq(1'b0, "R10 src0 still in service");
        wr(6'd4, 32'h0);
        expect_irq(1'b1, "R10 last retired");
        expect_rd(6'd3, 32'h20, "R10 src0 again");
        wr(6'd4, 32'h0);

        // R7 tie goes to lowest index
        wr(6'd17, 32'h0003_0021);
        pulse(1, 1'b0);
        pulse(0, 1'b0);
        expect_rd(6'd3, 32'h20, "R7 tie lowest index");
        wr(6'd4, 32'h0);
        expect_rd(6'd3, 32'h21, "R7 tie second");
        wr(6'd4, 32'h0);

        // constrained random against bench model
        @(negedge clk); rst_n = 1'b0; irq_in = '0;
        settle(2);
        rst_n = 1'b1;
        m_pend = '0; m_isr = '0; m_task = '0;
        wr(6'd0, 32'h1);
        for (int i = 0; i < NSRC; i++) begin
            m_pri[i] = 4'($urandom_range(15, 0));
            m_vec[i] = 8'($urandom_range(254, 0));
            wr(6'(16 + i), {8'h01, 4'h0, m_pri[i], 8'h00, m_vec[i]});
        end
        for (int n = 0; n < 300; n++) begin
            int op = int'($urandom_range(3, 0));
            if (op == 0) begin
                int s = int'($urandom_range(NSRC - 1, 0));
                pulse(s, 1'b0);
                m_pend[s] = 1'b1;
            end else if (op == 1) begin
                int w = model_win();
                if (w < 0) expect_rd(6'd3, 32'hFF, "R8 random spurious");
                else begin
                    expect_rd(6'd3, 32'(m_vec[w]), "R7 random ack");
                    m_pend[w] = 1'b0;
                    m_isr[w] = 1'b1;
                end
            end else if (op == 2) begin
                int t = model_top();
                wr(6'd4, 32'h0);
                if (t >= 0) m_isr[t] = 1'b0;
            end else begin
                m_task = 4'($urandom_range(7, 0));
                wr(6'd2, 32'(m_task));
            end
            expect_irq(model_win() >= 0, "R9 random irq");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule